// File: doc/BRIEF.md
# Seven-to-one display link deserializer

This block rebuilds parallel display words from a serial link made of four data lanes and one forwarded clock lane. Each lane carries seven bits per word period. The block samples every lane once per cycle of a bit-rate clock, at seven times the word rate. A seven-bit window slides over the clock lane. When that window holds the boundary mark, the block knows that the seven bits just shifted in on each data lane form one complete word. It then writes 24 colour bits and 4 control bits to a parallel output. The colour bits are eight red, eight green and eight blue. The control bits are line sync, frame sync, data enable and a spare control bit.

The block confirms alignment before it trusts the link. The mark must recur at the same bit phase for several words in a row before the block reports lock. While it is not locked, it drives zeros on the word and strobe outputs. It presents each word with a strobe. The falling edge of the strobe arrives with setup margin before it and hold margin after it. An active-low power-down input clears all state and holds every output low.

Top module: `dl7_deser`

## Requirements
- R1: Output bit `lane*7 + slot` comes from data lane `lane`. Slot 0 is the first of that lane's seven bits in time, and slot 6 is the last.
- R2: A word boundary is a clock-lane window that reads 1,1,0,0,0,1,1 in arrival order. This window may occur at any bit phase. The word is made of the seven bits that each data lane delivered over the same seven cycles.
- R3: `locked_o` rises one cycle after the fourth consecutive boundary, where each boundary comes exactly seven bit periods after the previous one.
- R4: While `locked_o` is low, `word_o` and `strobe_o` are zero.
- R5: While the block is locked, each word appears on `word_o` one cycle after the sample of its last bit. The word then stays unchanged for seven cycles.
- R6: `strobe_o` rises together with each word update and stays high for 4 cycles, then falls. `word_o` is unchanged across that falling edge.
- R7: A boundary that arrives at any spacing other than seven bit periods restarts the count. At least four boundaries at the correct spacing are then needed again before lock.
- R8: If no boundary arrives seven bit periods after the previous one, `locked_o`, `word_o` and `strobe_o` go low in the next cycle, and the search starts over.
- R9: While `pd_n` is low, all outputs are zero from the next cycle on and all alignment state is cleared. After `pd_n` is released, lock must be acquired again from scratch.
- R10: During and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate sampling clock (seven cycles per word) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down, synchronous clear |
| ck_lane_i | input | 1 | Forwarded clock lane, one bit per cycle |
| dat_lane_i | input | 4 | Data lanes, one bit per lane per cycle |
| word_o | output | 28 | Rebuilt parallel word |
| strobe_o | output | 1 | Word strobe; falling edge marks valid data |
| locked_o | output | 1 | Boundary alignment confirmed |

## Verification
A boundary is visible in the cycle after its seventh clock-lane bit is sampled. Lock, the new word and the rising strobe all register at the next edge. The strobe falls four edges after that. A missing boundary clears the outputs at the edge that ends the seventh cycle after the last boundary. Power-down clears the outputs at the first edge where it is low. The reference model advances on each rising edge, using the bits driven half a cycle earlier, and the outputs are compared with it on every falling edge. Targeted checks are also forked so that they land exactly two falling edges after the last bit of a word has been driven.

// File: rtl/dl7_pkg.sv
package dl7_pkg;

  localparam int unsigned DEF_LANES       = 4;
  localparam int unsigned DEF_SLOTS       = 7;
  localparam int unsigned DEF_LOCK_WORDS  = 4;
  localparam int unsigned DEF_STROBE_HIGH = 4;
  localparam logic [6:0]  DEF_MARK        = 7'b1100011;

  // position of a lane/slot pair in the rebuilt word
  function automatic int unsigned word_bit(input int unsigned lane,
                                           input int unsigned slot,
                                           input int unsigned slots);
    return lane * slots + slot;
  endfunction

  // window tap holding a given slot: newest bit sits at tap 0
  function automatic int unsigned tap_of_slot(input int unsigned slot,
                                              input int unsigned slots);
    return slots - 1 - slot;
  endfunction

  // saturating increment
  function automatic int unsigned sat_next(input int unsigned v,
                                           input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/dl7_lane_shift.sv
module dl7_lane_shift #(
  parameter int unsigned SLOTS = dl7_pkg::DEF_SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             bit_i,
  output logic [SLOTS-1:0] win_o
);

  logic [SLOTS-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (!pd_ni) begin
      win_q <= '0;
    end else begin
      win_q <= {win_q[SLOTS-2:0], bit_i};
    end
  end

  assign win_o = win_q;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_ni |=> (win_o[0] == $past(bit_i)));

  // R9
  shift_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (win_o == '0));

endmodule

// File: rtl/dl7_frame_lock.sv
module dl7_frame_lock #(
  parameter int unsigned     SLOTS      = dl7_pkg::DEF_SLOTS,
  parameter int unsigned     LOCK_WORDS = dl7_pkg::DEF_LOCK_WORDS,
  parameter logic [SLOTS-1:0] MARK      = dl7_pkg::DEF_MARK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [SLOTS-1:0] ck_win_i,
  output logic             hit_o,
  output logic             cap_o,
  output logic             lost_o,
  output logic             keep_o,
  output logic             locked_o
);
  import dl7_pkg::*;

  localparam int unsigned GW = $clog2(SLOTS + 1);
  localparam int unsigned SW = $clog2(LOCK_WORDS + 1);
  localparam logic [GW-1:0] GAP_IDLE = GW'(SLOTS);
  localparam logic [GW-1:0] GAP_STEP = GW'(SLOTS - 1);
  localparam logic [SW-1:0] STREAK_FULL = SW'(LOCK_WORDS);

  logic [GW-1:0] gap_q, gap_d;
  logic [SW-1:0] streak_q, streak_d;
  logic          hit, in_step, locked_d;

  assign hit     = (ck_win_i == MARK);
  assign in_step = (gap_q == GAP_STEP);

  always_comb begin
    streak_d = streak_q;
    if (hit) begin
      streak_d = in_step ? SW'(sat_next(int'(streak_q), LOCK_WORDS)) : SW'(1);
    end else if (in_step) begin
      streak_d = '0;
    end
  end

  always_comb begin
    if (hit) begin
      gap_d = '0;
    end else if (gap_q == GAP_IDLE) begin
      gap_d = GAP_IDLE;
    end else begin
      gap_d = gap_q + GW'(1);
    end
  end

  assign locked_d = (streak_d == STREAK_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= GAP_IDLE;
      streak_q <= '0;
    end else if (!pd_ni) begin
      gap_q    <= GAP_IDLE;
      streak_q <= '0;
    end else begin
      gap_q    <= gap_d;
      streak_q <= streak_d;
    end
  end

  assign hit_o    = hit;
  assign cap_o    = hit && locked_d && pd_ni;
  assign lost_o   = in_step && !hit;
  assign keep_o   = locked_d && pd_ni;
  assign locked_o = (streak_q == STREAK_FULL);

  // R3
  cap_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> locked_o);

  // R8
  lost_unlocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && pd_ni) |=> !locked_o);

  // R7
  off_step_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !in_step && pd_ni) |=> (!locked_o && streak_q == SW'(1)));

  // R9
  pd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (!locked_o && gap_q == GAP_IDLE));

endmodule

// File: rtl/dl7_word_out.sv
module dl7_word_out #(
  parameter int unsigned LANES       = dl7_pkg::DEF_LANES,
  parameter int unsigned SLOTS       = dl7_pkg::DEF_SLOTS,
  parameter int unsigned STROBE_HIGH = dl7_pkg::DEF_STROBE_HIGH,
  localparam int unsigned WORD_W     = LANES * SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              cap_i,
  input  logic              keep_i,
  input  logic [WORD_W-1:0] win_i,
  output logic [WORD_W-1:0] word_o,
  output logic              strobe_o
);
  import dl7_pkg::*;

  localparam int unsigned HW = $clog2(STROBE_HIGH + 1);
  localparam logic [HW-1:0] HIGH_LAST = HW'(STROBE_HIGH - 1);

  logic [WORD_W-1:0] mapped;
  logic [WORD_W-1:0] word_q;
  logic              strobe_q;
  logic [HW-1:0]     high_cnt_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign mapped[word_bit(l, s, SLOTS)] = win_i[l * SLOTS + tap_of_slot(s, SLOTS)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (!pd_ni || !keep_i) begin
      word_q <= '0;
    end else if (cap_i) begin
      word_q <= mapped;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q   <= 1'b0;
      high_cnt_q <= '0;
    end else if (!pd_ni || !keep_i) begin
      strobe_q   <= 1'b0;
      high_cnt_q <= '0;
    end else if (cap_i) begin
      strobe_q   <= 1'b1;
      high_cnt_q <= '0;
    end else if (strobe_q) begin
      if (high_cnt_q == HIGH_LAST) begin
        strobe_q <= 1'b0;
      end else begin
        high_cnt_q <= high_cnt_q + HW'(1);
      end
    end
  end

  assign word_o   = word_q;
  assign strobe_o = strobe_q;

  // R1
  first_bit_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (word_o[0] == $past(win_i[SLOTS-1])));

  // R6
  strobe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> strobe_o);

  // R6
  fall_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(strobe_o) && $past(keep_i) && $past(pd_ni)) |-> $stable(word_o));

  // R4
  unkept_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_i |=> (word_o == '0 && !strobe_o));

  // R9
  pd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (word_o == '0 && !strobe_o));

endmodule

// File: rtl/dl7_deser.sv
module dl7_deser #(
  parameter int unsigned LANES       = dl7_pkg::DEF_LANES,
  parameter int unsigned SLOTS       = dl7_pkg::DEF_SLOTS,
  parameter int unsigned LOCK_WORDS  = dl7_pkg::DEF_LOCK_WORDS,
  parameter int unsigned STROBE_HIGH = dl7_pkg::DEF_STROBE_HIGH,
  localparam int unsigned WORD_W     = LANES * SLOTS
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              ck_lane_i,
  input  logic [LANES-1:0]  dat_lane_i,
  output logic [WORD_W-1:0] word_o,
  output logic              strobe_o,
  output logic              locked_o
);

  logic [SLOTS-1:0]  ck_win;
  logic [WORD_W-1:0] dat_win_flat;
  logic              bnd_hit;
  logic              cap_evt;
  logic              lost_evt;
  logic              keep_lock;

  dl7_lane_shift #(.SLOTS(SLOTS)) u_ck_shift (
    .clk_i  (clk_bit),
    .rst_ni (rst_n),
    .pd_ni  (pd_n),
    .bit_i  (ck_lane_i),
    .win_o  (ck_win)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_dat
    dl7_lane_shift #(.SLOTS(SLOTS)) u_dat_shift (
      .clk_i  (clk_bit),
      .rst_ni (rst_n),
      .pd_ni  (pd_n),
      .bit_i  (dat_lane_i[g]),
      .win_o  (dat_win_flat[g*SLOTS +: SLOTS])
    );
  end

  dl7_frame_lock #(
    .SLOTS      (SLOTS),
    .LOCK_WORDS (LOCK_WORDS)
  ) u_lock (
    .clk_i    (clk_bit),
    .rst_ni   (rst_n),
    .pd_ni    (pd_n),
    .ck_win_i (ck_win),
    .hit_o    (bnd_hit),
    .cap_o    (cap_evt),
    .lost_o   (lost_evt),
    .keep_o   (keep_lock),
    .locked_o (locked_o)
  );

  dl7_word_out #(
    .LANES       (LANES),
    .SLOTS       (SLOTS),
    .STROBE_HIGH (STROBE_HIGH)
  ) u_out (
    .clk_i    (clk_bit),
    .rst_ni   (rst_n),
    .pd_ni    (pd_n),
    .cap_i    (cap_evt),
    .keep_i   (keep_lock),
    .win_i    (dat_win_flat),
    .word_o   (word_o),
    .strobe_o (strobe_o)
  );

  // R4
  unlocked_quiet_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !locked_o |-> (word_o == '0 && !strobe_o));

  // R5
  word_hold_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (locked_o && !cap_evt && keep_lock) |=> $stable(word_o));

  // R8
  lost_quiet_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (lost_evt && !bnd_hit) |=> (word_o == '0 && !strobe_o));

  // R10
  reset_quiet_chk: assert property (@(posedge clk_bit)
    !rst_n |-> (word_o == '0 && !strobe_o && !locked_o));

endmodule

// File: tb/dl7_deser_tb_top.sv
`timescale 1ns/1ps
module dl7_deser_tb_top;

  localparam int LN = 4;
  localparam int SL = 7;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk_bit = 1'b0;
  logic        rst_n   = 1'b0;
  logic        pd_n    = 1'b1;
  logic        ck_drv  = 1'b0;
  logic [3:0]  dat_drv = '0;
  logic [27:0] word_o;
  logic        strobe_o;
  logic        locked_o;

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 0;
  string cur_req  = "R10";

  always #2 clk_bit = ~clk_bit;

  dl7_deser dut_i (
    .clk_bit    (clk_bit),
    .rst_n      (rst_n),
    .pd_n       (pd_n),
    .ck_lane_i  (ck_drv),
    .dat_lane_i (dat_drv),
    .word_o     (word_o),
    .strobe_o   (strobe_o),
    .locked_o   (locked_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          ckq[SL];
  bit          dq[LN][SL];
  int          cyc = 0;
  int          streak = 0;
  int          last_hit = -1000;
  int          last_cap = -1000;
  logic [27:0] exp_word = '0;

  always @(posedge clk_bit) begin
    bit hit;
    cyc++;
    if (!rst_n || !pd_n) begin
      foreach (ckq[s]) ckq[s] = 0;
      foreach (dq[l, s]) dq[l][s] = 0;
      streak = 0; last_hit = -1000; last_cap = -1000; exp_word = '0;
    end else begin
      hit = 1;
      for (int s = 0; s < SL; s++) if (ckq[s] != PAT[s]) hit = 0;
      if (hit) begin
        streak = (cyc - last_hit == SL) ? ((streak < 4) ? streak + 1 : 4) : 1;
        last_hit = cyc;
        if (streak == 4) begin
          for (int l = 0; l < LN; l++)
            for (int s = 0; s < SL; s++) exp_word[l*SL + s] = dq[l][s];
          last_cap = cyc;
        end
      end else if (cyc - last_hit == SL) begin
        streak = 0;
      end
      if (streak < 4) exp_word = '0;
      for (int s = 0; s < SL-1; s++) begin
        ckq[s] = ckq[s+1];
        for (int l = 0; l < LN; l++) dq[l][s] = dq[l][s+1];
      end
      ckq[SL-1] = ck_drv;
      for (int l = 0; l < LN; l++) dq[l][SL-1] = dat_drv[l];
    end
  end

  // compare on every falling edge; collect words at strobe falls
  logic [27:0] got_q[$];
  bit          prev_strobe = 0;
  bit          collect = 0;

  always @(negedge clk_bit) begin
    bit exp_lock, exp_strobe;
    exp_lock   = (streak == 4);
    exp_strobe = exp_lock && (cyc - last_cap) < 4;
    chk(cur_req, {34'd0, locked_o, strobe_o, word_o},
                 {34'd0, exp_lock, exp_strobe, exp_word});
    if (collect && prev_strobe && !strobe_o) got_q.push_back(word_o);
    prev_strobe = strobe_o;
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bits(input int n, input logic [6:0] ck, input logic [27:0] d);
    for (int s = 0; s < n; s++) begin
      @(negedge clk_bit);
      ck_drv = ck[s];
      for (int l = 0; l < LN; l++) dat_drv[l] = d[l*SL + s];
    end
  endtask

  task automatic send_word(input logic [27:0] d);
    send_bits(SL, PAT, d);
  endtask

  task automatic idle(input int n);
    send_bits(1, 7'd0, 28'd0);
    for (int i = 1; i < n; i++) send_bits(1, 7'd0, 28'd0);
  endtask

  logic [27:0] w[10];

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk_bit);
    chk("R10", {35'd0, locked_o, strobe_o, word_o}, 64'd0);
    rst_n = 1'b1;

    w[0] = 28'h0000001; w[1] = 28'h8000000; w[2] = 28'hFFFFFFF; w[3] = 28'h0000081;
    w[4] = 28'h0204081; w[5] = 28'h5A5A5A5;
    for (int i = 6; i < 10; i++) w[i] = 28'($urandom());

    // R4: three words, no lock yet
    cur_req = "R4";
    collect = 1;
    for (int i = 0; i < 3; i++) send_word(w[i]);
    fork begin
      repeat (2) @(negedge clk_bit);
      chk("R4", {62'd0, locked_o, strobe_o}, 64'd0);
    end join_none
    // R3: fourth word locks, R1: mapping of the first captured word
    cur_req = "R3";
    send_word(w[3]);
    fork begin
      repeat (2) @(negedge clk_bit);
      chk("R3", {63'd0, locked_o}, 64'd1);
      chk("R1", {36'd0, word_o}, {36'd0, w[3]});
    end join_none
    cur_req = "R5";
    for (int i = 4; i < 10; i++) send_word(w[i]);
    // R8: missing boundary drops lock
    cur_req = "R8";
    idle(12);
    chk("R8", {63'd0, locked_o}, 64'd0);
    collect = 0;
    // R6 / R1: each locked word seen at its strobe fall
    chk("R6", 64'(got_q.size()), 64'd7);
    for (int i = 0; i < 7 && i < got_q.size(); i++)
      chk("R1", {36'd0, got_q[i]}, {36'd0, w[i+3]});

    // R2: boundary at a shifted bit phase
    cur_req = "R2";
    idle(3);
    for (int i = 0; i < 6; i++) send_word(28'($urandom()));
    chk("R2", {63'd0, locked_o}, 64'd1);

    // R7: off-spacing boundary restarts the count
    cur_req = "R7";
    idle(10);
    send_word(28'h1234567);
    send_bits(5, 7'b1100011 >> 2, 28'h0);
    for (int i = 0; i < 3; i++) send_word(28'($urandom()));
    fork begin
      repeat (2) @(negedge clk_bit);
      chk("R7", {63'd0, locked_o}, 64'd1);
    end join_none
    for (int i = 0; i < 3; i++) send_word(28'($urandom()));

    // R9: power-down while locked
    cur_req = "R9";
    @(negedge clk_bit);
    pd_n = 1'b0; ck_drv = 1'b0;
    @(negedge clk_bit);
    chk("R9", {35'd0, locked_o, strobe_o, word_o}, 64'd0);
    repeat (2) @(negedge clk_bit);
    pd_n = 1'b1;
    for (int i = 0; i < 3; i++) send_word(28'($urandom()));
    chk("R9", {63'd0, locked_o}, 64'd0);
    for (int i = 0; i < 3; i++) send_word(28'($urandom()));
    idle(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_bit);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule